// File: doc/BRIEF.md
# Aliased Model-Specific Register File

This block is a small file of model-specific registers reached through a single request port. Each request carries a 32-bit index, a read/write flag and 64 bits of write data. The block decodes the index, decides whether the access faults, and answers on the next clock with one of two results: a data word masked to the implemented width of the selected entry, or a one-cycle fault pulse.

The upper-bound test on the index treats it as a signed number. A negative index, meaning bit 31 is set, therefore always passes the test. Only its low five bits choose an entry, so the top half of the index space folds onto 32 entries. Three low indices are refused by an explicit match, but their aliases in the top half are accepted. Entries that cannot be read return a fixed marker instead of data. A few entries carry behaviour of their own: a free-running 64-bit counter, a write that halts the block until reset, a probe-control word with one bit taken from a pin, and two scratch words.

Top module: `msr_alias_file`

## Requirements
- R1: A request faults when bit 31 of the index is clear and the index is above 14h. Indices 00h to 14h and every index with bit 31 set are accepted, unless R3 applies.
- R2: An accepted index with bit 31 set selects entry `index[4:0]`. Indices that differ only in bits 30 to 5 reach the same storage.
- R3: Low indices 03h, 0Ah and 0Fh fault. Indices 80000003h, 8000000Ah and 8000000Fh are accepted.
- R4: A read of a write-only or unimplemented entry returns upper 32 bits of zero and a lower word equal to the entry number times two. These entries are 02h, 03h, 07h, 0Ah, 0Dh, 0Eh, 0Fh and 15h to 17h.
- R5: A write to a read/write entry keeps only the implemented bits, and a read returns zero above them. The widths are: 04h 4 bits; 11h 26 bits; 12h and 13h 40 bits; 1Bh 11 bits; 05h, 06h, 08h, 09h, 0Bh, 0Ch, 1Eh and 1Fh 32 bits.
- R6: Entry 10h is a 64-bit counter. It increments on every clock and wraps to zero. A write loads it, and a read one clock after the write returns the written value.
- R7: Writing 1 to bit 0 through an accepted index to entry 0Fh halts the block. From that response onward the response outputs float and requests are ignored. Writing 0 has no effect. Only reset leaves the halt.
- R8: Entry 1Dh reads as follows: bit 31 is the probe flag input, sampled when the request is taken; bits 2 to 0 are the last values written; every other bit is zero.
- R9: Entries 1Eh and 1Fh are 32-bit scratch words that reset to zero. Writes to entries 15h to 17h change nothing.
- R10: A faulting request changes no state. Its response has the fault output high for one cycle and the valid output low.
- R11: Read-only entries ignore writes. Entries 18h and 1Ch read 4. Entries 00h, 01h, 14h, 19h and 1Ah read 0.
- R12: Each request taken while not halted gets exactly one response, on the clock after it. A write response carries zero data. After reset, valid and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per high cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register index |
| req_wdata | input | 64 | Write data |
| probe_mode_flag | input | 1 | Value presented in bit 31 of entry 1Dh |
| rsp_valid | output | 1 | Accepted response strobe (floats when halted) |
| rsp_fault | output | 1 | Fault pulse (floats when halted) |
| rsp_rdata | output | 64 | Read data, zero for writes (floats when halted) |

## Verification
Every result, whether read data, fault pulse or write acknowledgement, is due exactly one clock after the edge that takes the request. The counter value seen by a read is the value written plus the number of edges between the write and the read, minus one. The driver stamps each expected item with the cycle in which it must appear. The monitor compares only in that cycle and flags any response that shows up when nothing is due. That includes the silence expected once the halt has taken effect.

// File: rtl/msr_alias_pkg.sv
// Package msr_alias_pkg
// Shared sizes, entry classes and per-entry attribute functions for the
// aliased register file. Assumes a 5-bit entry space (32 entries).
package msr_alias_pkg;

    localparam int IDX_W      = 32;
    localparam int DATA_W     = 64;
    localparam int ENT_W      = 5;
    localparam int N_ENT      = 1 << ENT_W;
    localparam int HALF_W     = DATA_W / 2;
    localparam int PROBE_BITS = 3;

    // Low indices refused by explicit match
    localparam logic [IDX_W-1:0] BLOCK_A = 32'h0000_0003;
    localparam logic [IDX_W-1:0] BLOCK_B = 32'h0000_000A;
    localparam logic [IDX_W-1:0] BLOCK_C = 32'h0000_000F;

    typedef logic [ENT_W-1:0] ent_t;

    typedef enum logic [2:0] {
        K_RO,
        K_RW,
        K_WO,
        K_CNT,
        K_PROBE,
        K_HALT
    } ent_kind_e;

    // Class of each entry
    function automatic ent_kind_e kind_of(ent_t e);
        ent_kind_e k;
        case (e)
            5'h00, 5'h01, 5'h14, 5'h18, 5'h19, 5'h1A, 5'h1C: k = K_RO;
            5'h04, 5'h05, 5'h06, 5'h08, 5'h09, 5'h0B, 5'h0C,
            5'h11, 5'h12, 5'h13, 5'h1B, 5'h1E, 5'h1F:        k = K_RW;
            5'h10:                                           k = K_CNT;
            5'h1D:                                           k = K_PROBE;
            5'h0F:                                           k = K_HALT;
            default:                                         k = K_WO;
        endcase
        return k;
    endfunction

    // Implemented width of each storing entry
    function automatic int width_of(ent_t e);
        int w;
        case (e)
            5'h04:                w = 4;
            5'h01:                w = 6;
            5'h1B, 5'h19, 5'h1A:  w = 11;
            5'h11:                w = 26;
            5'h12, 5'h13:         w = 40;
            5'h00, 5'h10:         w = DATA_W;
            default:              w = HALF_W;
        endcase
        return w;
    endfunction

    // Bit mask of implemented bits
    function automatic logic [DATA_W-1:0] mask_of(ent_t e);
        int w;
        w = width_of(e);
        if (w >= DATA_W) return '1;
        return (DATA_W'(1) << w) - DATA_W'(1);
    endfunction

    // Fixed contents of read-only entries
    function automatic logic [DATA_W-1:0] ro_value(ent_t e);
        logic [DATA_W-1:0] v;
        case (e)
            5'h18, 5'h1C: v = DATA_W'(4);
            default:      v = '0;
        endcase
        return v & mask_of(e);
    endfunction

    // Marker returned by entries that cannot be read
    function automatic logic [DATA_W-1:0] wo_marker(ent_t e);
        return {{HALF_W{1'b0}}, {(HALF_W-ENT_W-1){1'b0}}, e, 1'b0};
    endfunction

endpackage

// File: rtl/msr_index_decode.sv
// Module msr_index_decode
// Combinational index decode: folds the index to an entry number, applies
// the signed upper-bound test and the explicit low-index refusals.
// Assumes LOW_LIMIT is a non-negative value below 2^31.
module msr_index_decode
    import msr_alias_pkg::*;
#(
    parameter int LOW_LIMIT = 20
) (
    input  logic [IDX_W-1:0] index,
    output ent_t             entry,
    output ent_kind_e        kind,
    output logic             fault
);

    localparam logic [IDX_W-1:0] LIMIT_V = IDX_W'(LOW_LIMIT);

    logic over_limit;
    logic blocked;

    // Entry selection, signed bound test and explicit refusals
    always_comb begin
        entry      = index[ENT_W-1:0];
        kind       = kind_of(entry);
        over_limit = $signed(index) > $signed(LIMIT_V);
        blocked    = (index == BLOCK_A) || (index == BLOCK_B) || (index == BLOCK_C);
        fault      = over_limit || blocked;
    end

endmodule

// File: rtl/msr_entry_store.sv
// Module msr_entry_store
// State of the register file: masked read/write words, the cycle counter,
// the probe-control bits and the halt flag, plus the read multiplexer.
// Assumes wr_en is already qualified (accepted, not faulted, not halted).
module msr_entry_store
    import msr_alias_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  ent_t              wr_entry,
    input  logic [DATA_W-1:0] wr_data,
    input  ent_t              rd_entry,
    input  logic              probe_flag,
    output logic [DATA_W-1:0] rd_data,
    output logic              halted
);

    logic [DATA_W-1:0]     bank [N_ENT];
    logic [DATA_W-1:0]     cnt_q;
    logic [PROBE_BITS-1:0] probe_q;
    logic                  halt_q;
    ent_kind_e             wr_kind;
    ent_kind_e             rd_kind;

    assign wr_kind = kind_of(wr_entry);
    assign rd_kind = kind_of(rd_entry);
    assign halted  = halt_q;

    // Plain read/write words, masked on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) bank[i] <= '0;
        end else if (wr_en && wr_kind == K_RW) begin
            bank[wr_entry] <= wr_data & mask_of(wr_entry);
        end
    end

    // Free-running counter with load
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (wr_en && wr_kind == K_CNT)  cnt_q <= wr_data;
        else                                 cnt_q <= cnt_q + DATA_W'(1);
    end

    // Probe-control writable bits
    always_ff @(posedge clk) begin
        if (!rst_n)                            probe_q <= '0;
        else if (wr_en && wr_kind == K_PROBE)  probe_q <= wr_data[PROBE_BITS-1:0];
    end

    // Sticky halt, left only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)                                       halt_q <= 1'b0;
        else if (wr_en && wr_kind == K_HALT && wr_data[0]) halt_q <= 1'b1;
    end

    // Read multiplexer by entry class
    always_comb begin
        case (rd_kind)
            K_RW:    rd_data = bank[rd_entry];
            K_CNT:   rd_data = cnt_q;
            K_PROBE: rd_data = {{HALF_W{1'b0}}, probe_flag,
                                {(HALF_W-1-PROBE_BITS){1'b0}}, probe_q};
            K_RO:    rd_data = ro_value(rd_entry);
            default: rd_data = wo_marker(rd_entry);
        endcase
    end

endmodule

// File: rtl/msr_alias_file.sv
// Module msr_alias_file
// Top of the aliased register file. Takes one request per req_valid cycle,
// answers one clock later with data or a fault pulse, and floats its
// response outputs once halted. Assumes synchronous active-low reset.
module msr_alias_file
    import msr_alias_pkg::*;
#(
    parameter int LOW_LIMIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              probe_mode_flag,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [DATA_W-1:0] rsp_rdata
);

    ent_t              entry;
    ent_kind_e         kind;
    logic              fault;
    logic              halted_q;
    logic              accept;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;
    logic              rsp_valid_q;
    logic              rsp_fault_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    msr_index_decode #(.LOW_LIMIT(LOW_LIMIT)) u_decode (
        .index (req_index),
        .entry (entry),
        .kind  (kind),
        .fault (fault)
    );

    assign accept = req_valid && !halted_q;
    assign wr_en  = accept && req_write && !fault;

    msr_entry_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_entry   (entry),
        .wr_data    (req_wdata),
        .rd_entry   (entry),
        .probe_flag (probe_mode_flag),
        .rd_data    (rd_data),
        .halted     (halted_q)
    );

    // Response register, one clock after the request
    always_ff @(posedge clk) begin
        if (!rst_n || !accept) begin
            rsp_valid_q <= 1'b0;
            rsp_fault_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= !fault;
            rsp_fault_q <= fault;
            rsp_rdata_q <= (fault || req_write) ? '0 : rd_data;
        end
    end

    // Outputs float once halted
    assign rsp_valid = halted_q ? 1'bz : rsp_valid_q;
    assign rsp_fault = halted_q ? 1'bz : rsp_fault_q;
    assign rsp_rdata = halted_q ? {DATA_W{1'bz}} : rsp_rdata_q;

endmodule

// File: rtl/msr_alias_file_checker.sv
// Module msr_alias_file_checker
// Temporal properties of the register file, attached by bind.
module msr_alias_file_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_index,
    input logic        halted_q,
    input logic        rsp_valid_q,
    input logic        rsp_fault_q
);

    AST_VALID_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid_q && rsp_fault_q)); // R10

    AST_REQ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !halted_q) |=> (rsp_valid_q || rsp_fault_q)); // R12

    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_q || rsp_fault_q) |-> $past(req_valid)); // R12

    AST_LOW_RANGE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !halted_q && !req_index[31] && req_index > 32'h14) |=> rsp_fault_q); // R1

    AST_HIGH_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !halted_q && req_index[31]) |=> !rsp_fault_q); // R2

    AST_LOW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !halted_q && (req_index == 32'h3 || req_index == 32'hA || req_index == 32'hF))
        |=> rsp_fault_q); // R3

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> halted_q); // R7

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> (!rsp_valid_q && !rsp_fault_q)); // R7

endmodule

bind msr_alias_file msr_alias_file_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_index   (req_index),
    .halted_q    (halted_q),
    .rsp_valid_q (rsp_valid_q),
    .rsp_fault_q (rsp_fault_q)
);

// File: tb/msr_alias_file_bench.sv
// Scoreboard bench: the driver queues expectations stamped with their due
// cycle, the monitor pops and compares them at the falling edge.
module msr_alias_file_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_index = '0;
    logic [63:0] req_wdata = '0;
    logic        probe_mode_flag = 1'b0;
    wire         rsp_valid;
    wire         rsp_fault;
    wire  [63:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        int          due;
        bit          none;
        bit          flt;
        logic [63:0] data;
        string       tag;
    } exp_t;

    exp_t sb[$];

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    msr_alias_file u_msr_alias_file (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_write       (req_write),
        .req_index       (req_index),
        .req_wdata       (req_wdata),
        .probe_mode_flag (probe_mode_flag),
        .rsp_valid       (rsp_valid),
        .rsp_fault       (rsp_fault),
        .rsp_rdata       (rsp_rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic issue(input bit wr, input logic [31:0] idx, input logic [63:0] wd,
                         input bit none, input bit flt, input logic [63:0] exp_d,
                         input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_index = idx;
        req_wdata = wd;
        e.due = cyc + 1; e.none = none; e.flt = flt; e.data = exp_d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic rd(input logic [31:0] idx, input logic [63:0] exp_d, input string tag);
        issue(1'b0, idx, '0, 1'b0, 1'b0, exp_d, tag);
    endtask

    task automatic wr(input logic [31:0] idx, input logic [63:0] wd, input string tag);
        issue(1'b1, idx, wd, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic flt(input bit w, input logic [31:0] idx, input string tag);
        issue(w, idx, '0, 1'b0, 1'b1, '0, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
        end
    endtask

    // Monitor: compare due items, reject unexpected responses
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (e.none) begin
                    if (rsp_valid === 1'b1 || rsp_fault === 1'b1) begin
                        fails++;
                        $display("FAIL %s: valid=%b fault=%b, expected no response",
                                 e.tag, rsp_valid, rsp_fault);
                    end
                end else if (rsp_fault !== e.flt || rsp_valid !== !e.flt ||
                             (!e.flt && rsp_rdata !== e.data)) begin
                    fails++;
                    $display("FAIL %s: valid=%b fault=%b data=%h, expected fault=%b data=%h",
                             e.tag, rsp_valid, rsp_fault, rsp_rdata, e.flt, e.data);
                end
            end else if (rsp_valid === 1'b1 || rsp_fault === 1'b1) begin
                checks++;
                fails++;
                $display("FAIL R12: unexpected response valid=%b fault=%b, expected none",
                         rsp_valid, rsp_fault);
            end
        end
    end

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run still active, expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0) begin
            fails++;
            $display("FAIL R12: reset valid=%b fault=%b, expected 0 0", rsp_valid, rsp_fault);
        end

        // Range check (R1) and aliasing (R2)
        rd(32'h0000_0014, 64'h0, "R1 idx 14h accepted");
        flt(1'b0, 32'h0000_0015, "R1 idx 15h faults");
        flt(1'b0, 32'h7FFF_FFFF, "R1 idx 7FFFFFFFh faults");
        rd(32'h8000_0000, 64'h0, "R1 idx 80000000h accepted");
        rd(32'h8000_001E, 64'h0, "R9 scratch resets to zero");
        wr(32'h8000_001E, 64'hDEAD_BEEF_1234_5678, "R9 scratch write");
        rd(32'hFFFF_FFFE, 64'h1234_5678, "R2 alias FFFFFFFEh reaches entry 1Eh");
        wr(32'hC000_003F, 64'h0000_0000_CAFE_F00D, "R2 alias write entry 1Fh");
        rd(32'h8000_001F, 64'hCAFE_F00D, "R9 scratch 1Fh readback");

        // Explicit refusals (R3) and write-only marker (R4)
        flt(1'b0, 32'h0000_0003, "R3 idx 03h faults");
        flt(1'b0, 32'h0000_000A, "R3 idx 0Ah faults");
        flt(1'b0, 32'h0000_000F, "R3 idx 0Fh faults");
        rd(32'h8000_0003, 64'h6, "R3 alias 03h marker");
        rd(32'h8000_000A, 64'h14, "R3 alias 0Ah marker");
        rd(32'h0000_0002, 64'h4, "R4 entry 02h marker");
        rd(32'h8000_0015, 64'h2A, "R4 entry 15h marker");
        wr(32'h8000_0016, ONES, "R9 write to 16h");
        rd(32'h8000_0016, 64'h2C, "R9 entry 16h unchanged");

        // Width masking (R5)
        wr(32'h0000_0004, ONES, "R5 write 04h");
        rd(32'h0000_0004, 64'hF, "R5 entry 04h 4 bits");
        wr(32'h0000_0011, ONES, "R5 write 11h");
        rd(32'h0000_0011, 64'h3FF_FFFF, "R5 entry 11h 26 bits");
        wr(32'h0000_0012, ONES, "R5 write 12h");
        rd(32'h0000_0012, 64'hFF_FFFF_FFFF, "R5 entry 12h 40 bits");
        wr(32'h8000_001B, ONES, "R5 write 1Bh");
        rd(32'h8000_001B, 64'h7FF, "R5 entry 1Bh 11 bits");
        wr(32'h0000_0005, ONES, "R5 write 05h");
        rd(32'h0000_0005, 64'hFFFF_FFFF, "R5 entry 05h 32 bits");

        // Faulting write leaves state (R10)
        flt(1'b1, 32'h0000_0024, "R10 faulting write");
        rd(32'h0000_0004, 64'hF, "R10 entry 04h unchanged after fault");

        // Read-only entries (R11)
        wr(32'h8000_0018, 64'h0, "R11 write to 18h");
        rd(32'h8000_0018, 64'h4, "R11 entry 18h reads 4");
        wr(32'h0000_0001, ONES, "R11 write to 01h");
        rd(32'h0000_0001, 64'h0, "R11 entry 01h unchanged");
        rd(32'h8000_001C, 64'h4, "R11 entry 1Ch reads 4");

        // Counter (R6)
        wr(32'h0000_0010, 64'h100, "R6 load counter");
        rd(32'h0000_0010, 64'h100, "R6 read right after load");
        idle(3);
        rd(32'h8000_0010, 64'h104, "R6 counts every clock");
        wr(32'h8000_0010, ONES, "R6 load all ones");
        rd(32'h0000_0010, ONES, "R6 read all ones");
        rd(32'h0000_0010, 64'h0, "R6 wraps to zero");

        // Probe word (R8)
        probe_mode_flag = 1'b1;
        wr(32'h8000_001D, ONES, "R8 probe write");
        rd(32'h8000_001D, 64'h8000_0007, "R8 probe with flag high");
        @(negedge clk); probe_mode_flag = 1'b0; req_valid = 1'b0;
        rd(32'h8000_001D, 64'h0000_0007, "R8 probe with flag low");
        wr(32'h8000_001D, 64'h0, "R8 probe clear");
        rd(32'h8000_001D, 64'h0, "R8 probe cleared");

        // Halt (R7)
        wr(32'h8000_000F, 64'h0, "R7 zero write no halt");
        rd(32'h8000_001E, 64'h1234_5678, "R7 still running after zero write");
        flt(1'b1, 32'h0000_000F, "R7 low 0Fh write faults");
        rd(32'h8000_001E, 64'h1234_5678, "R7 still running after faulting write");
        issue(1'b1, 32'h8000_000F, 64'h1, 1'b1, 1'b0, '0, "R7 halting write silent");
        issue(1'b0, 32'h8000_001E, '0, 1'b1, 1'b0, '0, "R7 halted read ignored");
        issue(1'b0, 32'h0000_0015, '0, 1'b1, 1'b0, '0, "R7 halted fault ignored");
        idle(2);

        // Reset leaves halt and clears storage (R7, R9)
        do_reset();
        rd(32'h8000_001E, 64'h0, "R7 running after reset, scratch zero");
        rd(32'h0000_0004, 64'h0, "R9 entry 04h reset to zero");
        idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule